// File: doc/BRIEF.md
# Thread-Block Dispatcher with Per-Slot Resource Ledger

This block takes one launch of a grid of equally sized thread blocks and hands the blocks to a small array of multiprocessor slots. It sends one block per clock cycle at most. A block goes to a slot only if that slot has all four of these free at the same time: a block entry, enough thread capacity, enough registers and enough shared memory. The reservation is made when the offer is raised. It is held until the slot reports that the block has completed. At that point the entry, threads, registers and shared bytes all go back to the slot, and blocks still waiting may use them.

Each block's register demand is its thread count multiplied by its registers per thread. Registers are taken from a pool that belongs to each slot. Because every block of a launch has the same size, resident block entry `k` owns the contiguous register range that starts at `k` times the block's demand. The dispatch offer carries the block index, the entry number and that base register. The slot must quote the entry number back when it reports completion.

The launch port and each per-slot dispatch port are valid/ready. A launch is taken only while the dispatcher is idle, that is, while `launch_ready` is high. A raised dispatch offer keeps its valid bit and all its fields unchanged until that slot asserts ready. While it waits, no other block is offered on any slot. Completion inputs, the error pulse and the done pulse are plain single-cycle signals.

Top module: `block_dispatcher`

## Requirements
- R1: After reset, `launch_ready` is 1, and `disp_valid`, `launch_err` and `launch_done` are all 0.
- R2: A launch is rejected if it has zero blocks, zero threads or more than 512 threads per block, needs more than 8192 registers per block, or needs more than 16384 shared bytes. On a rejection `launch_err` pulses for one cycle, in the cycle after acceptance. No block is dispatched and `launch_ready` stays 1. A launch of exactly 512 threads and 8192 registers per block is legal.
- R3: A launch is taken only while `launch_ready` is 1. From the cycle after a legal launch until `launch_done`, `launch_ready` is 0 and `launch_valid` is ignored.
- R4: Blocks are offered in index order 0, 1, 2 and so on. At most one `disp_valid` bit is high at a time. With ready held high, offers follow on consecutive cycles, and the first offer comes one cycle after acceptance.
- R5: The slot search starts at the slot after the last slot that received a block, and the first slot with room wins. After reset the last slot is taken to be the highest-numbered slot, so block 0 goes to slot 0.
- R6: A slot never holds more than 8 resident blocks.
- R7: A slot never holds more than 768 resident threads.
- R8: A slot never reserves more than 8192 registers. A block placed in the lowest free entry `k` gets `disp_reg_base` = `k` × threads × registers-per-thread, and `disp_entry` = `k`.
- R9: A slot never reserves more than 16384 shared-memory bytes. A launch that needs exactly 16384 bytes per block places one block per slot.
- R10: When `done_valid[s]` is presented with `done_entry` naming an occupied entry of slot `s`, that block's resources are freed and the next waiting block can use them. A completion that names an unoccupied entry is ignored.
- R11: While an offer's valid bit is high and its ready bit is low, the valid bit, block index, entry and base register of that offer stay unchanged, and no other block is offered.
- R12: `launch_done` pulses for one cycle, in the cycle after the cycle in which the last block's completion was presented. In that same cycle `launch_ready` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| launch_valid | input | 1 | Launch request valid |
| launch_ready | output | 1 | Dispatcher idle; a launch is accepted on valid and ready |
| launch_blocks | input | BLK_W | Number of blocks in the grid |
| launch_threads | input | TW | Threads per block |
| launch_regs_per_thr | input | RPT_W | Registers per thread |
| launch_shmem | input | HW | Shared-memory bytes per block |
| launch_err | output | 1 | One-cycle pulse when a launch is rejected |
| launch_done | output | 1 | One-cycle pulse when every block has completed |
| disp_valid | output | NUM_SLOTS | Per-slot dispatch offer valid |
| disp_ready | input | NUM_SLOTS | Per-slot dispatch offer ready |
| disp_blk_idx | output | NUM_SLOTS*BLK_W | Per-slot offered block index |
| disp_entry | output | NUM_SLOTS*EW | Per-slot block entry used by the offer |
| disp_reg_base | output | NUM_SLOTS*RW | Per-slot first register of the offered block |
| done_valid | input | NUM_SLOTS | Per-slot block completion strobe |
| done_entry | input | NUM_SLOTS*EW | Per-slot entry of the completed block |

## Verification
A launch is accepted on a rising edge. A rejection shows on `launch_err` in the cycle right after that edge. For a legal launch, the first offer becomes visible one cycle after that edge, and each following offer comes one cycle after the previous handshake. A completion frees the slot at the edge that ends the presentation cycle, so a block that was waiting for that slot is offered in the second cycle after it. `launch_done` follows the cycle of the last completion by exactly one cycle. The bench drives inputs one nanosecond after the rising edge and samples on the falling edge. Each check is either aligned to one of these latencies, counted from recorded cycle numbers, or made only after a settling window longer than the latency, when the check is about a limit (dispatch has stopped).

// File: rtl/blkdisp_pkg.sv
package blkdisp_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;

  // index width that never collapses to zero bits
  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/blkdisp_slot_ledger.sv
module blkdisp_slot_ledger #(
  parameter int BLOCKS  = 8,
  parameter int THREADS = 768,
  parameter int REGS    = 8192,
  parameter int SHMEM   = 16384,
  parameter int EW      = 3,
  parameter int TW      = 10,
  parameter int RW      = 14,
  parameter int HW      = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reserve,
  input  logic          free_req,
  input  logic [EW-1:0] free_entry_in,
  input  logic [TW-1:0] need_thr,
  input  logic [RW-1:0] need_reg,
  input  logic [HW-1:0] need_shm,
  output logic          fits,
  output logic [EW-1:0] open_entry,
  output logic          free_ok
);

  logic [BLOCKS-1:0] occ;
  logic [TW-1:0]     thr_left;
  logic [RW-1:0]     reg_left;
  logic [HW-1:0]     shm_left;
  logic              has_open;

  // lowest unoccupied entry
  always_comb begin
    has_open   = 1'b0;
    open_entry = '0;
    for (int e = BLOCKS - 1; e >= 0; e--) begin
      if (!occ[e]) begin
        has_open   = 1'b1;
        open_entry = EW'(e);
      end
    end
  end

  // a completion counts only for an entry that is really held
  assign free_ok = free_req && (int'(free_entry_in) < BLOCKS) && occ[free_entry_in];

  // all four limits must have room together
  assign fits = has_open
             && (thr_left >= need_thr)
             && (reg_left >= need_reg)
             && (shm_left >= need_shm);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ      <= '0;
      thr_left <= TW'(THREADS);
      reg_left <= RW'(REGS);
      shm_left <= HW'(SHMEM);
    end else begin
      if (free_ok) occ[free_entry_in] <= 1'b0;
      if (reserve) occ[open_entry]    <= 1'b1;
      thr_left <= thr_left - (reserve ? need_thr : '0) + (free_ok ? need_thr : '0);
      reg_left <= reg_left - (reserve ? need_reg : '0) + (free_ok ? need_reg : '0);
      shm_left <= shm_left - (reserve ? need_shm : '0) + (free_ok ? need_shm : '0);
    end
  end

endmodule

// File: rtl/blkdisp_rr_picker.sv
module blkdisp_rr_picker #(
  parameter int N  = 4,
  parameter int SW = 2
) (
  input  logic [N-1:0]  fits,
  input  logic [SW-1:0] last,
  output logic          any,
  output logic [SW-1:0] pick
);

  int cand;

  // scan from the slot after the previous winner, wrapping once
  always_comb begin
    any  = 1'b0;
    pick = last;
    cand = 0;
    for (int i = 1; i <= N; i++) begin
      cand = (int'(last) + i) % N;
      if (!any && fits[cand]) begin
        any  = 1'b1;
        pick = cand[SW-1:0];
      end
    end
  end

endmodule

// File: rtl/blkdisp_ctrl.sv
module blkdisp_ctrl
  import blkdisp_pkg::*;
#(
  parameter int NUM_SLOTS   = 4,
  parameter int BLK_THR_MAX = 512,
  parameter int SLOT_REGS   = 8192,
  parameter int SLOT_SHMEM  = 16384,
  parameter int BLK_W       = 16,
  parameter int RPT_W       = 8,
  parameter int SW          = 2,
  parameter int EW          = 3,
  parameter int TW          = 10,
  parameter int RW          = 14,
  parameter int HW          = 15,
  parameter int CW          = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 launch_valid,
  input  logic [BLK_W-1:0]     launch_blocks,
  input  logic [TW-1:0]        launch_threads,
  input  logic [RPT_W-1:0]     launch_regs_per_thr,
  input  logic [HW-1:0]        launch_shmem,
  output logic                 launch_ready,
  output logic                 launch_err,
  output logic                 launch_done,
  input  logic                 grant_any,
  input  logic [SW-1:0]        grant_slot,
  input  logic [EW-1:0]        sel_entry,
  input  logic [NUM_SLOTS-1:0] disp_ready,
  input  logic [CW-1:0]        rel_cnt,
  output logic                 issue,
  output logic [SW-1:0]        last_slot,
  output logic                 pend,
  output logic [SW-1:0]        pend_slot,
  output logic [BLK_W-1:0]     pend_blk,
  output logic [EW-1:0]        pend_entry,
  output logic [RW-1:0]        pend_base,
  output logic [TW-1:0]        need_thr,
  output logic [RW-1:0]        need_reg,
  output logic [HW-1:0]        need_shm
);

  localparam int PW = TW + RPT_W;

  run_state_e       st;
  logic [BLK_W-1:0] total;
  logic [BLK_W-1:0] nxt;
  logic [BLK_W-1:0] ndone;
  logic [BLK_W:0]   ndone_n;
  logic [PW-1:0]    prod;
  logic             bad;
  logic             hs;

  assign launch_ready = (st == ST_IDLE);
  assign prod = PW'(launch_threads) * PW'(launch_regs_per_thr);

  assign bad = (launch_blocks == '0)
            || (launch_threads == '0)
            || (int'(launch_threads) > BLK_THR_MAX)
            || (int'(prod) > SLOT_REGS)
            || (int'(launch_shmem) > SLOT_SHMEM);

  assign hs      = pend && disp_ready[pend_slot];
  assign issue   = (st == ST_RUN) && (!pend || hs) && (nxt < total) && grant_any;
  assign ndone_n = {1'b0, ndone} + (BLK_W + 1)'(rel_cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      total       <= '0;
      nxt         <= '0;
      ndone       <= '0;
      need_thr    <= '0;
      need_reg    <= '0;
      need_shm    <= '0;
      pend        <= 1'b0;
      pend_slot   <= '0;
      pend_blk    <= '0;
      pend_entry  <= '0;
      pend_base   <= '0;
      last_slot   <= SW'(NUM_SLOTS - 1);
      launch_err  <= 1'b0;
      launch_done <= 1'b0;
    end else begin
      launch_err  <= 1'b0;
      launch_done <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (launch_valid) begin
            if (bad) begin
              launch_err <= 1'b1;
            end else begin
              st       <= ST_RUN;
              total    <= launch_blocks;
              need_thr <= launch_threads;
              need_reg <= prod[RW-1:0];
              need_shm <= launch_shmem;
              nxt      <= '0;
              ndone    <= '0;
            end
          end
        end
        ST_RUN: begin
          if (hs && !issue) pend <= 1'b0;
          if (issue) begin
            pend       <= 1'b1;
            pend_slot  <= grant_slot;
            pend_blk   <= nxt;
            pend_entry <= sel_entry;
            pend_base  <= RW'(sel_entry) * need_reg;
            last_slot  <= grant_slot;
            nxt        <= nxt + 1'b1;
          end
          ndone <= ndone_n[BLK_W-1:0];
          if (ndone_n == {1'b0, total}) begin
            st          <= ST_IDLE;
            launch_done <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/block_dispatcher.sv
module block_dispatcher
  import blkdisp_pkg::*;
#(
  parameter int NUM_SLOTS    = 4,
  parameter int SLOT_BLOCKS  = 8,
  parameter int SLOT_THREADS = 768,
  parameter int SLOT_REGS    = 8192,
  parameter int SLOT_SHMEM   = 16384,
  parameter int BLK_THR_MAX  = 512,
  parameter int BLK_W        = 16,
  parameter int RPT_W        = 8,
  localparam int SW = idx_bits(NUM_SLOTS),
  localparam int EW = idx_bits(SLOT_BLOCKS),
  localparam int TW = $clog2(SLOT_THREADS + 1),
  localparam int RW = $clog2(SLOT_REGS + 1),
  localparam int HW = $clog2(SLOT_SHMEM + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    launch_valid,
  output logic                    launch_ready,
  input  logic [BLK_W-1:0]        launch_blocks,
  input  logic [TW-1:0]           launch_threads,
  input  logic [RPT_W-1:0]        launch_regs_per_thr,
  input  logic [HW-1:0]           launch_shmem,
  output logic                    launch_err,
  output logic                    launch_done,
  output logic [NUM_SLOTS-1:0]    disp_valid,
  input  logic [NUM_SLOTS-1:0]    disp_ready,
  output logic [NUM_SLOTS*BLK_W-1:0] disp_blk_idx,
  output logic [NUM_SLOTS*EW-1:0] disp_entry,
  output logic [NUM_SLOTS*RW-1:0] disp_reg_base,
  input  logic [NUM_SLOTS-1:0]    done_valid,
  input  logic [NUM_SLOTS*EW-1:0] done_entry
);

  localparam int CW = $clog2(NUM_SLOTS + 1);

  logic [NUM_SLOTS-1:0] slot_fits;
  logic [NUM_SLOTS-1:0] slot_free_ok;
  logic [EW-1:0]        slot_open [NUM_SLOTS];
  logic                 grant_any;
  logic [SW-1:0]        grant_slot;
  logic [SW-1:0]        last_slot;
  logic                 issue;
  logic                 pend;
  logic [SW-1:0]        pend_slot;
  logic [BLK_W-1:0]     pend_blk;
  logic [EW-1:0]        pend_entry;
  logic [RW-1:0]        pend_base;
  logic [TW-1:0]        need_thr;
  logic [RW-1:0]        need_reg;
  logic [HW-1:0]        need_shm;
  logic [CW-1:0]        rel_cnt;

  always_comb begin
    rel_cnt = '0;
    for (int s = 0; s < NUM_SLOTS; s++) rel_cnt = rel_cnt + CW'(slot_free_ok[s]);
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    blkdisp_slot_ledger #(
      .BLOCKS (SLOT_BLOCKS), .THREADS(SLOT_THREADS), .REGS(SLOT_REGS), .SHMEM(SLOT_SHMEM),
      .EW(EW), .TW(TW), .RW(RW), .HW(HW)
    ) u_ledger (
      .clk          (clk),
      .rst_n        (rst_n),
      .reserve      (issue && (grant_slot == SW'(s))),
      .free_req     (done_valid[s]),
      .free_entry_in(done_entry[s*EW +: EW]),
      .need_thr     (need_thr),
      .need_reg     (need_reg),
      .need_shm     (need_shm),
      .fits         (slot_fits[s]),
      .open_entry   (slot_open[s]),
      .free_ok      (slot_free_ok[s])
    );

    assign disp_valid[s]                 = pend && (pend_slot == SW'(s));
    assign disp_blk_idx[s*BLK_W +: BLK_W] = disp_valid[s] ? pend_blk   : '0;
    assign disp_entry[s*EW +: EW]         = disp_valid[s] ? pend_entry : '0;
    assign disp_reg_base[s*RW +: RW]      = disp_valid[s] ? pend_base  : '0;
  end

  blkdisp_rr_picker #(.N(NUM_SLOTS), .SW(SW)) u_pick (
    .fits(slot_fits),
    .last(last_slot),
    .any (grant_any),
    .pick(grant_slot)
  );

  blkdisp_ctrl #(
    .NUM_SLOTS(NUM_SLOTS), .BLK_THR_MAX(BLK_THR_MAX), .SLOT_REGS(SLOT_REGS),
    .SLOT_SHMEM(SLOT_SHMEM), .BLK_W(BLK_W), .RPT_W(RPT_W),
    .SW(SW), .EW(EW), .TW(TW), .RW(RW), .HW(HW), .CW(CW)
  ) u_ctrl (
    .clk                (clk),
    .rst_n              (rst_n),
    .launch_valid       (launch_valid),
    .launch_blocks      (launch_blocks),
    .launch_threads     (launch_threads),
    .launch_regs_per_thr(launch_regs_per_thr),
    .launch_shmem       (launch_shmem),
    .launch_ready       (launch_ready),
    .launch_err         (launch_err),
    .launch_done        (launch_done),
    .grant_any          (grant_any),
    .grant_slot         (grant_slot),
    .sel_entry          (slot_open[grant_slot]),
    .disp_ready         (disp_ready),
    .rel_cnt            (rel_cnt),
    .issue              (issue),
    .last_slot          (last_slot),
    .pend               (pend),
    .pend_slot          (pend_slot),
    .pend_blk           (pend_blk),
    .pend_entry         (pend_entry),
    .pend_base          (pend_base),
    .need_thr           (need_thr),
    .need_reg           (need_reg),
    .need_shm           (need_shm)
  );

endmodule

// File: rtl/block_dispatcher_chk.sv
module block_dispatcher_chk #(
  parameter int NS = 4,
  parameter int BW = 16,
  parameter int EW = 3,
  parameter int RW = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             launch_ready,
  input logic             launch_err,
  input logic             launch_done,
  input logic [NS-1:0]    disp_valid,
  input logic [NS-1:0]    disp_ready,
  input logic [NS*BW-1:0] disp_blk_idx,
  input logic [NS*EW-1:0] disp_entry,
  input logic [NS*RW-1:0] disp_reg_base
);

  // R11
  hold_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(disp_valid & ~disp_ready)) |=> (disp_valid == $past(disp_valid))
      && $stable(disp_blk_idx) && $stable(disp_entry) && $stable(disp_reg_base));

  // R4
  single_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(disp_valid));

  // R2
  reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch_err |-> (disp_valid == '0) && launch_ready);

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch_ready |-> (disp_valid == '0));

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch_done |=> !launch_done);

  // R12
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch_done |-> launch_ready && !launch_err);

endmodule

bind block_dispatcher block_dispatcher_chk #(
  .NS(NUM_SLOTS), .BW(BLK_W), .EW(EW), .RW(RW)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .launch_ready (launch_ready),
  .launch_err   (launch_err),
  .launch_done  (launch_done),
  .disp_valid   (disp_valid),
  .disp_ready   (disp_ready),
  .disp_blk_idx (disp_blk_idx),
  .disp_entry   (disp_entry),
  .disp_reg_base(disp_reg_base)
);

// File: tb/block_dispatcher_tb.sv
`timescale 1ns/1ps
module block_dispatcher_tb;

  localparam int NS = 4;
  localparam int BW = 16;
  localparam int EW = 3;
  localparam int TW = 10;
  localparam int RW = 14;
  localparam int HW = 15;
  localparam int RPW = 8;
  localparam int MAXREC = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic launch_valid = 1'b0;
  logic launch_ready;
  logic [BW-1:0] launch_blocks = '0;
  logic [TW-1:0] launch_threads = '0;
  logic [RPW-1:0] launch_regs_per_thr = '0;
  logic [HW-1:0] launch_shmem = '0;
  logic launch_err, launch_done;
  logic [NS-1:0] disp_valid;
  logic [NS-1:0] disp_ready = '1;
  logic [NS*BW-1:0] disp_blk_idx;
  logic [NS*EW-1:0] disp_entry;
  logic [NS*RW-1:0] disp_reg_base;
  logic [NS-1:0] done_valid = '0;
  logic [NS*EW-1:0] done_entry = '0;

  int chk_cnt = 0;
  int fail_cnt = 0;
  int cyc = 0;
  int n_rec = 0;
  int rec_slot [MAXREC];
  int rec_blk  [MAXREC];
  int rec_ent  [MAXREC];
  int rec_base [MAXREC];
  int rec_cyc  [MAXREC];
  bit freed    [MAXREC];
  int base_n;
  int launch_cyc;

  always #2.5 clk = ~clk;

  block_dispatcher u_dut (
    .clk(clk), .rst_n(rst_n),
    .launch_valid(launch_valid), .launch_ready(launch_ready),
    .launch_blocks(launch_blocks), .launch_threads(launch_threads),
    .launch_regs_per_thr(launch_regs_per_thr), .launch_shmem(launch_shmem),
    .launch_err(launch_err), .launch_done(launch_done),
    .disp_valid(disp_valid), .disp_ready(disp_ready),
    .disp_blk_idx(disp_blk_idx), .disp_entry(disp_entry), .disp_reg_base(disp_reg_base),
    .done_valid(done_valid), .done_entry(done_entry)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // record every handshake seen before the edge that completes it
  always @(negedge clk) begin
    if (rst_n) begin
      for (int s = 0; s < NS; s++) begin
        if (disp_valid[s] && disp_ready[s] && n_rec < MAXREC) begin
          rec_slot[n_rec] = s;
          rec_blk[n_rec]  = int'(disp_blk_idx[s*BW +: BW]);
          rec_ent[n_rec]  = int'(disp_entry[s*EW +: EW]);
          rec_base[n_rec] = int'(disp_reg_base[s*RW +: RW]);
          rec_cyc[n_rec]  = cyc;
          n_rec = n_rec + 1;
        end
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    chk_cnt++;
    if (act != exp) begin
      fail_cnt++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int k);
    repeat (k) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0; launch_valid = 1'b0; disp_ready = '1; done_valid = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    base_n = n_rec;
  endtask

  task automatic launch(input int blocks, input int thr, input int rpt, input int shm);
    @(posedge clk); #1;
    launch_valid = 1'b1;
    launch_blocks = BW'(blocks);
    launch_threads = TW'(thr);
    launch_regs_per_thr = RPW'(rpt);
    launch_shmem = HW'(shm);
    @(posedge clk);
    launch_cyc = cyc + 1;
    #1 launch_valid = 1'b0;
  endtask

  // return every resident block, slot by slot, until the launch reports done
  task automatic drain(input string tag, input int total);
    bit prev_any = 1'b0;
    bit seen = 1'b0;
    for (int k = 0; k < 400 && !seen; k++) begin
      bit any = 1'b0;
      @(posedge clk); #1;
      done_valid = '0;
      for (int s = 0; s < NS; s++) begin
        for (int i = base_n; i < n_rec; i++) begin
          if (!done_valid[s] && rec_slot[i] == s && !freed[i]) begin
            done_valid[s] = 1'b1;
            done_entry[s*EW +: EW] = EW'(rec_ent[i]);
            freed[i] = 1'b1;
            any = 1'b1;
          end
        end
      end
      @(negedge clk);
      if (launch_done) begin
        seen = 1'b1;
        // R12: done one cycle after the final completion was presented
        check({tag, " R12 done after last completion"}, int'(prev_any), 1);
        check({tag, " R12 all blocks dispatched"}, n_rec - base_n, total);
        check({tag, " R12 ready back"}, int'(launch_ready), 1);
      end
      prev_any = any;
    end
    done_valid = '0;
    check({tag, " R12 done seen"}, int'(seen), 1);
    @(negedge clk);
    check({tag, " R12 single pulse"}, int'(launch_done), 0);
  endtask

  task automatic t_reset_state();
    do_reset();
    check("R1 ready", int'(launch_ready), 1);
    check("R1 valid", int'(disp_valid), 0);
    check("R1 err", int'(launch_err), 0);
    check("R1 done", int'(launch_done), 0);
  endtask

  task automatic reject_one(input string tag, input int b, input int t, input int r, input int sh);
    launch(b, t, r, sh);
    @(negedge clk);
    check({tag, " R2 err pulse"}, int'(launch_err), 1);
    check({tag, " R2 stays ready"}, int'(launch_ready), 1);
    wait_cyc(4);
    check({tag, " R2 err cleared"}, int'(launch_err), 0);
    check({tag, " R2 no dispatch"}, n_rec - base_n, 0);
  endtask

  task automatic t_reject();
    do_reset();
    reject_one("thr513", 1, 513, 1, 0);
    reject_one("thr0", 1, 0, 1, 0);
    reject_one("blk0", 0, 32, 1, 0);
    reject_one("shm", 1, 32, 1, 16385);
    reject_one("regs", 1, 512, 17, 0);
    launch(1, 512, 16, 0);
    @(negedge clk);
    check("R2 max legal no err", int'(launch_err), 0);
    wait_cyc(4);
    check("R2 max legal dispatched", n_rec - base_n, 1);
    drain("max", 1);
  endtask

  task automatic t_order_rr();
    do_reset();
    launch(6, 32, 4, 0);
    @(negedge clk);
    check("R3 busy after launch", int'(launch_ready), 0);
    @(posedge clk); #1;
    launch_valid = 1'b1; launch_blocks = 1; launch_threads = 0;
    repeat (3) @(posedge clk);
    #1 launch_valid = 1'b0;
    @(negedge clk);
    check("R3 second launch ignored", int'(launch_err), 0);
    wait_cyc(8);
    check("R4 count", n_rec - base_n, 6);
    for (int i = 0; i < 6; i++) begin
      int j = base_n + i;
      check("R4 index order", rec_blk[j], i);
      check("R5 slot order", rec_slot[j], i % NS);
      check("R8 entry", rec_ent[j], i / NS);
      check("R8 base", rec_base[j], (i / NS) * 128);
      check("R4 one per cycle", rec_cyc[j] - rec_cyc[base_n], i);
    end
    check("R4 first latency", rec_cyc[base_n] - launch_cyc, 1);
    drain("order", 6);
  endtask

  task automatic t_entry_limit();
    do_reset();
    launch(40, 1, 1, 0);
    wait_cyc(50);
    check("R6 eight per slot", n_rec - base_n, 32);
    @(posedge clk); #1;
    done_valid = 4'b0100; done_entry[2*EW +: EW] = 3;
    for (int i = base_n; i < n_rec; i++)
      if (rec_slot[i] == 2 && rec_ent[i] == 3) freed[i] = 1'b1;
    @(posedge clk); #1;
    done_valid = '0;
    wait_cyc(4);
    check("R10 freed slot reused", n_rec - base_n, 33);
    check("R10 reuse slot", rec_slot[base_n + 32], 2);
    check("R10 reuse entry", rec_ent[base_n + 32], 3);
    check("R4 reuse index", rec_blk[base_n + 32], 32);
    check("R8 reuse base", rec_base[base_n + 32], 3);
    drain("entries", 40);
  endtask

  task automatic t_thread_limit();
    do_reset();
    launch(14, 256, 1, 0);
    wait_cyc(30);
    check("R7 three per slot", n_rec - base_n, 12);
    @(posedge clk); #1;
    done_valid = 4'b0001; done_entry[0 +: EW] = 5;
    @(posedge clk); #1;
    done_valid = '0;
    wait_cyc(5);
    check("R10 stray completion ignored", n_rec - base_n, 12);
    drain("threads", 14);
  endtask

  task automatic t_reg_limit();
    do_reset();
    launch(10, 256, 11, 0);
    wait_cyc(30);
    check("R8 two per slot", n_rec - base_n, 8);
    check("R8 second entry base", rec_base[base_n + 4], 2816);
    check("R8 second entry", rec_ent[base_n + 4], 1);
    drain("regs", 10);
  endtask

  task automatic t_shm_limit();
    do_reset();
    launch(15, 32, 1, 5000);
    wait_cyc(30);
    check("R9 three per slot", n_rec - base_n, 12);
    drain("shm", 15);
    base_n = n_rec;
    launch(5, 32, 1, 16384);
    @(negedge clk);
    check("R9 full size legal", int'(launch_err), 0);
    wait_cyc(20);
    check("R9 one per slot", n_rec - base_n, 4);
    drain("shmfull", 5);
  endtask

  task automatic t_backpressure();
    do_reset();
    disp_ready = 4'b1110;
    launch(3, 32, 1, 0);
    wait_cyc(2);
    check("R11 held valid", int'(disp_valid), 1);
    check("R11 held index", int'(disp_blk_idx[0 +: BW]), 0);
    wait_cyc(3);
    check("R11 still held", int'(disp_valid), 1);
    check("R11 no other offer", n_rec - base_n, 0);
    @(posedge clk); #1;
    disp_ready = '1;
    wait_cyc(6);
    check("R11 released count", n_rec - base_n, 3);
    check("R11 slot after release", rec_slot[base_n + 1], 1);
    drain("bp", 3);
  endtask

  initial begin
    t_reset_state();
    t_reject();
    t_order_rr();
    t_entry_limit();
    t_thread_limit();
    t_reg_limit();
    t_shm_limit();
    t_backpressure();
    $display("End of test - %0d assertions evaluated, %0d failures", chk_cnt, fail_cnt);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    fail_cnt++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", chk_cnt, fail_cnt);
    $finish;
  end

endmodule